// File: doc/BRIEF.md
# Banked Candidate Scheduler

This block is the hardwired sequencer that keeps an evolvable filter array busy. A processor writes candidate configurations into a set of banks, one candidate per bank, and marks each bank valid. The scheduler walks the banks in a fixed circular order. For each valid bank it presents that bank's configuration to the filter array one column per cycle, as a bank index and a column index. It starts the fitness evaluation once the first column is in place. When the last column is in, it marks the bank empty and moves to the next bank.

The fitness unit warns a few cycles before an evaluation ends. That warning starts the next reconfiguration, so evaluations run back to back. Each finished fitness value is paired with the bank it belongs to and queued. An interrupt stays asserted while the queue holds results. The processor acknowledges the head result and writes a fresh candidate into the freed bank. The configuration memory, the filter array and the fitness datapath sit outside the block and appear here only as handshake signals.

The controller has four states:
- `ST_IDLE` (stopped). It goes to `ST_WAIT` when `run_en` is high.
- `ST_WAIT` (waiting for the current bank). It goes to `ST_LOAD` when the bank is ready, and back to `ST_IDLE` when `run_en` drops.
- `ST_LOAD` (one column per cycle). It goes to `ST_EVAL` after the last column.
- `ST_EVAL` (evaluation running). On the early-end warning it goes to `ST_LOAD` when running and the next bank is ready, to `ST_WAIT` when running and the bank is not ready, and to `ST_IDLE` when stopped.

Top module: `cand_sched`

## Requirements
- R1: After reset the controller is in `ST_IDLE`, all bank valid bits are clear, the bank pointer is 0, `col_load`, `fit_start` and `irq` are low, and the result queue is empty.
- R2: In `ST_WAIT`, loading starts on the next cycle only when the current bank is valid and the queue has room (R9). Otherwise the controller stays in `ST_WAIT` and holds the bank pointer. It never skips to another bank.
- R3: During a load, `col_load` is high for exactly NUM_COLS consecutive cycles. `col_idx` runs 0, 1, … NUM_COLS-1, one step per cycle.
- R4: `fit_start` is a one-cycle pulse. It is high in the cycle that presents column 1, which is the cycle after column 0 has been loaded.
- R5: In the cycle after the last column, the loaded bank's valid bit is clear and the bank pointer has advanced by one. The pointer wraps from NUM_BANKS-1 to 0. `col_bank` shows the bank pointer during a load.
- R6: In `ST_EVAL`, a `fit_early_end` pulse moves the controller to `ST_LOAD` (column 0 next cycle) when `run_en` is high and the next bank is ready. When `run_en` is high and the bank is not ready it moves to `ST_WAIT`, and when `run_en` is low it moves to `ST_IDLE`.
- R7: Each `fit_done` pairs `fit_value` with the bank of the oldest evaluation started and not yet finished. The pair is appended to the result queue. `irq` is high while the queue is non-empty, and `irq_bank`/`irq_fitness` show the oldest entry.
- R8: A cycle with `irq_ack` high removes the oldest queue entry. `irq_ack` while the queue is empty has no effect.
- R9: A new load is not started while the queued results plus the started but unfinished evaluations equal RES_DEPTH. A result is therefore never dropped.
- R10: `refill_we` sets the valid bit of `refill_bank` from the next cycle on. If the same bank is cleared at its last column in that cycle, the set wins.
- R11: While `run_en` is low, no new load starts. A load already in progress completes, and the controller then reaches `ST_IDLE` after the early-end warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run (1) or stop after current evaluation (0) |
| refill_we | input | 1 | Processor marks `refill_bank` valid |
| refill_bank | input | BW | Bank written by the processor |
| col_load | output | 1 | A configuration column is presented this cycle |
| col_idx | output | CW | Column being presented |
| col_bank | output | BW | Bank whose column is presented |
| fit_start | output | 1 | Start pulse to the fitness unit |
| fit_early_end | input | 1 | Fitness unit warns that the evaluation is about to end |
| fit_done | input | 1 | Fitness value is valid this cycle |
| fit_value | input | FIT_W | Fitness of the finished evaluation |
| irq | output | 1 | Result pending for the processor |
| irq_bank | output | BW | Bank of the oldest pending result |
| irq_fitness | output | FIT_W | Fitness of the oldest pending result |
| irq_ack | input | 1 | Processor consumes the oldest result |

## Verification
All outputs are decoded from registers, so an input seen at one rising edge shows its effect one cycle later:
- Column 0 appears in the cycle after the ready decision.
- `fit_start` follows one cycle after column 0.
- A `fit_done` or `irq_ack` changes `irq`, `irq_bank` and `irq_fitness` from the next cycle on.

The bench keeps a behavioural model built from queues. The model is advanced at each rising edge from the same inputs the design sees, and it is compared with the outputs at the falling edge, half a cycle after the edge that settled them. Inputs are driven just after the falling edge, so every comparison sees a quiet state. The emulated fitness unit raises its warning seven or more cycles after `fit_start` and its result three cycles later. This gives back-to-back evaluations with two in flight, and a spacing of exactly early-end offset plus two cycles between starts.

// File: rtl/cand_sched_pkg.sv
package cand_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_LOAD = 2'd2,
        ST_EVAL = 2'd3
    } sched_state_t;

endpackage

// File: rtl/cand_fifo.sv
module cand_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]   LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CNTW-1:0] cnt;
    logic            do_push;
    logic            do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULL_CNT);
    assign count   = cnt;
    assign dout    = mem[rd_ptr];
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !(pop && !empty)) |-> !full);

    // R8
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/cand_bank_valid.sv
module cand_bank_valid #(
    parameter int NUM_BANKS = 8,
    parameter int BW        = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [BW-1:0]        set_idx,
    input  logic                 clr_en,
    input  logic [BW-1:0]        clr_idx,
    output logic [NUM_BANKS-1:0] valid
);
    logic [NUM_BANKS-1:0] valid_q;

    assign valid = valid_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[b] <= 1'b0;
            end else if (set_en && (set_idx == BW'(b))) begin
                valid_q[b] <= 1'b1;
            end else if (clr_en && (clr_idx == BW'(b))) begin
                valid_q[b] <= 1'b0;
            end
        end
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> valid_q[$past(set_idx)]);

endmodule

// File: rtl/cand_sched_fsm.sv
module cand_sched_fsm
    import cand_sched_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int NUM_COLS  = 8,
    parameter int BW        = 3,
    parameter int CW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          early_end,
    input  logic          bank_ready,
    output logic [BW-1:0] bank,
    output logic [CW-1:0] col,
    output logic          col_load,
    output logic          fit_start,
    output logic          last_col
);
    localparam logic [CW-1:0] LAST_COL  = CW'(NUM_COLS - 1);
    localparam logic [BW-1:0] LAST_BANK = BW'(NUM_BANKS - 1);

    sched_state_t  state;
    sched_state_t  state_nxt;
    logic [CW-1:0] col_nxt;
    logic [BW-1:0] bank_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            col   <= '0;
            bank  <= '0;
        end else begin
            state <= state_nxt;
            col   <= col_nxt;
            bank  <= bank_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        col_nxt   = col;
        bank_nxt  = bank;
        unique case (state)
            ST_IDLE: begin
                if (run_en) state_nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (!run_en) begin
                    state_nxt = ST_IDLE;
                end else if (bank_ready) begin
                    state_nxt = ST_LOAD;
                    col_nxt   = '0;
                end
            end
            ST_LOAD: begin
                if (col == LAST_COL) begin
                    state_nxt = ST_EVAL;
                    col_nxt   = '0;
                    bank_nxt  = (bank == LAST_BANK) ? '0 : bank + 1'b1;
                end else begin
                    col_nxt = col + 1'b1;
                end
            end
            ST_EVAL: begin
                if (early_end) begin
                    if (run_en && bank_ready) begin
                        state_nxt = ST_LOAD;
                        col_nxt   = '0;
                    end else if (run_en) begin
                        state_nxt = ST_WAIT;
                    end else begin
                        state_nxt = ST_IDLE;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        col_load  = (state == ST_LOAD);
        fit_start = col_load && (col == CW'(1));
        last_col  = col_load && (col == LAST_COL);
    end

    // R3
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_load && col != '0) |-> ($past(col_load) && col == $past(col) + 1'b1));

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fit_start |=> !fit_start);

    // R5
    bank_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_col && bank == LAST_BANK) |=> (bank == '0 && !col_load));

    // R11
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !col_load && state != ST_EVAL) |=> !col_load);

    // R2
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !bank_ready) |=> (!col_load && $stable(bank)));

endmodule

// File: rtl/cand_sched.sv
module cand_sched #(
    parameter int NUM_BANKS = 8,
    parameter int NUM_COLS  = 8,
    parameter int FIT_W     = 24,
    parameter int RES_DEPTH = 4,
    localparam int BW       = $clog2(NUM_BANKS),
    localparam int CW       = $clog2(NUM_COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             refill_we,
    input  logic [BW-1:0]    refill_bank,
    output logic             col_load,
    output logic [CW-1:0]    col_idx,
    output logic [BW-1:0]    col_bank,
    output logic             fit_start,
    input  logic             fit_early_end,
    input  logic             fit_done,
    input  logic [FIT_W-1:0] fit_value,
    output logic             irq,
    output logic [BW-1:0]    irq_bank,
    output logic [FIT_W-1:0] irq_fitness,
    input  logic             irq_ack
);
    localparam int CNTW  = $clog2(RES_DEPTH + 1);
    localparam int SUMW  = CNTW + 1;
    localparam int RES_W = BW + FIT_W;
    localparam logic [SUMW-1:0] LIMIT = SUMW'(RES_DEPTH);

    logic [BW-1:0]        cur_bank;
    logic [CW-1:0]        cur_col;
    logic                 last_col;
    logic                 bank_ready;
    logic [NUM_BANKS-1:0] valid;
    logic [BW-1:0]        tag_dout;
    logic                 tag_empty;
    logic                 tag_full;
    logic [CNTW-1:0]      tag_cnt;
    logic [RES_W-1:0]     res_dout;
    logic                 res_empty;
    logic                 res_full;
    logic [CNTW-1:0]      res_cnt;
    logic [SUMW-1:0]      occupancy;

    assign occupancy  = {1'b0, res_cnt} + {1'b0, tag_cnt};
    assign bank_ready = valid[cur_bank] && (occupancy < LIMIT);

    cand_sched_fsm #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_COLS  (NUM_COLS),
        .BW        (BW),
        .CW        (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .early_end  (fit_early_end),
        .bank_ready (bank_ready),
        .bank       (cur_bank),
        .col        (cur_col),
        .col_load   (col_load),
        .fit_start  (fit_start),
        .last_col   (last_col)
    );

    cand_bank_valid #(
        .NUM_BANKS (NUM_BANKS),
        .BW        (BW)
    ) u_valid (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (refill_we),
        .set_idx (refill_bank),
        .clr_en  (last_col),
        .clr_idx (cur_bank),
        .valid   (valid)
    );

    cand_fifo #(
        .W     (BW),
        .DEPTH (RES_DEPTH)
    ) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fit_start),
        .din   (cur_bank),
        .pop   (fit_done),
        .dout  (tag_dout),
        .empty (tag_empty),
        .full  (tag_full),
        .count (tag_cnt)
    );

    cand_fifo #(
        .W     (RES_W),
        .DEPTH (RES_DEPTH)
    ) u_results (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fit_done),
        .din   ({tag_dout, fit_value}),
        .pop   (irq_ack),
        .dout  (res_dout),
        .empty (res_empty),
        .full  (res_full),
        .count (res_cnt)
    );

    assign col_idx     = cur_col;
    assign col_bank    = cur_bank;
    assign irq         = !res_empty;
    assign irq_bank    = res_dout[FIT_W +: BW];
    assign irq_fitness = res_dout[FIT_W-1:0];

    // R7
    done_has_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fit_done |-> !tag_empty);

    // R9
    tag_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fit_start |-> !tag_full);

    // R9
    result_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fit_done |-> (!res_full || irq_ack));

    // R5
    bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_col && !(refill_we && refill_bank == cur_bank)) |=> !valid[$past(cur_bank)]);

    // R2
    load_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_load) ##1 col_load |-> $past(valid[cur_bank]));

endmodule

// File: tb/tb_cand_sched.sv
module tb_cand_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int NC = 8;
    localparam int FW = 24;
    localparam int RD = 4;
    localparam int BW = 3;
    localparam int CW = 3;
    localparam int WD_LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          refill_we = 1'b0;
    logic [BW-1:0] refill_bank = '0;
    logic          fit_early_end = 1'b0;
    logic          fit_done = 1'b0;
    logic [FW-1:0] fit_value = '0;
    logic          irq_ack = 1'b0;
    logic          col_load;
    logic [CW-1:0] col_idx;
    logic [BW-1:0] col_bank;
    logic          fit_start;
    logic          irq;
    logic [BW-1:0] irq_bank;
    logic [FW-1:0] irq_fitness;

    cand_sched #(.NUM_BANKS(NB), .NUM_COLS(NC), .FIT_W(FW), .RES_DEPTH(RD)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .refill_we(refill_we),
        .refill_bank(refill_bank), .col_load(col_load), .col_idx(col_idx),
        .col_bank(col_bank), .fit_start(fit_start), .fit_early_end(fit_early_end),
        .fit_done(fit_done), .fit_value(fit_value), .irq(irq), .irq_bank(irq_bank),
        .irq_fitness(irq_fitness), .irq_ack(irq_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    int ncyc = 0;
    int wd = 0;
    int ee_off = 7;
    int seq = 0;
    int n_starts = 0;
    int n_loadcyc = 0;
    int ee_q[$];
    int dn_q[$];
    int start_t[$];

    // reference model: 0 idle, 1 wait, 2 load, 3 eval
    int m_st, m_bank, m_col, m_t;
    bit m_valid[NB];
    bit m_rdy, m_ack_ok;
    int m_tag[$];
    int m_rb[$];
    int m_rf[$];

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_bank = 0; m_col = 0;
            foreach (m_valid[i]) m_valid[i] = 1'b0;
            m_tag.delete(); m_rb.delete(); m_rf.delete();
        end else begin
            m_rdy = m_valid[m_bank] && ((m_rb.size() + m_tag.size()) < RD);
            m_ack_ok = irq_ack && (m_rb.size() > 0);
            m_t = 0;
            if (fit_done && m_tag.size() > 0) m_t = m_tag.pop_front();
            if (m_ack_ok) begin
                void'(m_rb.pop_front());
                void'(m_rf.pop_front());
            end
            if (fit_done) begin
                m_rb.push_back(m_t);
                m_rf.push_back(int'(fit_value));
            end
            if (m_st == 2 && m_col == 1) m_tag.push_back(m_bank);
            if (m_st == 2 && m_col == NC-1) m_valid[m_bank] = 1'b0;
            if (refill_we) m_valid[refill_bank] = 1'b1;
            case (m_st)
                0: if (run_en) m_st = 1;
                1: begin
                    if (!run_en) m_st = 0;
                    else if (m_rdy) begin m_st = 2; m_col = 0; end
                end
                2: begin
                    if (m_col == NC-1) begin
                        m_st = 3; m_col = 0; m_bank = (m_bank + 1) % NB;
                    end else m_col++;
                end
                default: begin
                    if (fit_early_end) begin
                        if (run_en && m_rdy) begin m_st = 2; m_col = 0; end
                        else if (run_en) m_st = 1;
                        else m_st = 0;
                    end
                end
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2 R6 R9 R11 col_load", int'(col_load), int'(m_st == 2));
            if (m_st == 2) begin
                chk("R3 col_idx", int'(col_idx), m_col);
                chk("R5 R10 col_bank", int'(col_bank), m_bank);
            end
            chk("R4 fit_start", int'(fit_start), int'(m_st == 2 && m_col == 1));
            chk("R7 R8 irq", int'(irq), int'(m_rb.size() > 0));
            if (m_rb.size() > 0) begin
                chk("R7 irq_bank", int'(irq_bank), m_rb[0]);
                chk("R7 irq_fitness", int'(irq_fitness), m_rf[0]);
            end
        end
    end

    // emulated fitness unit
    always @(negedge clk) begin
        ncyc++;
        if (col_load) n_loadcyc++;
        #1;
        fit_early_end = 1'b0;
        fit_done = 1'b0;
        if (fit_start) begin
            ee_q.push_back(ncyc + ee_off);
            dn_q.push_back(ncyc + ee_off + 3);
            start_t.push_back(ncyc);
            n_starts++;
        end
        if (ee_q.size() > 0 && ee_q[0] == ncyc) begin
            fit_early_end = 1'b1;
            void'(ee_q.pop_front());
        end
        if (dn_q.size() > 0 && dn_q[0] == ncyc) begin
            fit_done = 1'b1;
            fit_value = FW'(24'h0A0000 + seq * 4099);
            seq++;
            void'(dn_q.pop_front());
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", wd, WD_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic service(int n, bit do_ack);
        repeat (n) begin
            @(negedge clk);
            #2;
            irq_ack = 1'b0;
            refill_we = 1'b0;
            if (do_ack && irq) begin
                irq_ack = 1'b1;
                refill_we = 1'b1;
                refill_bank = irq_bank;
            end
        end
        @(negedge clk);
        #2;
        irq_ack = 1'b0;
        refill_we = 1'b0;
    endtask

    int loads_at_stop;

    initial begin
        tick(4);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 col_load after reset", int'(col_load), 0);
        chk("R1 fit_start after reset", int'(fit_start), 0);
        chk("R1 irq after reset", int'(irq), 0);
        #2;
        run_en = 1'b1;
        tick(12);
        chk("R1 R2 no load while every bank invalid", n_loadcyc, 0);
        // R8 acknowledge with empty queue
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        tick(1);
        chk("R8 ack on empty queue ignored", int'(irq), 0);
        // fill all banks
        for (int b = 0; b < NB; b++) begin
            refill_we = 1'b1;
            refill_bank = BW'(b);
            tick(1);
        end
        refill_we = 1'b0;
        tick(150);
        chk("R9 evaluations before stall on full queue", n_starts, RD);
        chk("R9 irq held with full queue", int'(irq), 1);
        chk("R6 back-to-back start spacing", start_t[1] - start_t[0], ee_off + 2);
        chk("R5 R7 oldest result is bank 0", int'(irq_bank), 0);
        // processor services results and refills banks
        service(400, 1'b1);
        chk("R5 bank pointer wrapped", int'(n_starts > NB + RD), 1);
        // R11 stop while a load is in progress
        while (!col_load) @(negedge clk);
        #2;
        run_en = 1'b0;
        service(40, 1'b1);
        loads_at_stop = n_loadcyc;
        service(40, 1'b1);
        chk("R11 no load after stop", n_loadcyc, loads_at_stop);
        // restart with a slower fitness unit
        ee_off = 12;
        run_en = 1'b1;
        service(200, 1'b1);
        run_en = 1'b0;
        service(120, 1'b1);
        chk("R8 queue drained by acknowledges", int'(irq), 0);
        chk("R11 idle after final stop", int'(col_load), 0);
        summary();
        $finish;
    end
endmodule